// File: doc/BRIEF.md
# I2C Master Bit Engine

This block drives an I2C bus as its only master. It works from the system clock and advances in fixed steps of one quarter-bit tick. The tick length is a parameter. Both bus lines are open-drain. The engine only ever pulls a line low through an output enable, and pull-ups outside the block raise the lines when they are released. The engine reads the data line level back through a separate input.

The engine takes one command at a time:
- bus recovery
- START
- STOP
- write one byte
- read one byte, with a chosen acknowledge level

It raises `busy_o` while a command runs. It pulses `done_o` for one cycle when the command ends. The received byte and the sampled acknowledge bit stay on `rdata_o` and `ack_o` until the next command overwrites them. A transaction layer above the engine builds complete transfers out of these commands.

Top module: `i2c_bit_engine`

## Requirements
- R1: START (code 1) first releases SDA, then releases SCL, then pulls SDA low while SCL stays high, with one tick per step. It lasts 4 ticks and leaves SCL released and SDA pulled low.
- R2: STOP (code 2) pulls SCL low, then pulls SDA low, then releases SCL, then releases SDA while SCL is high, with one tick per step. It lasts 4 ticks and leaves both lines released.
- R3: Write (code 3) sends `wdata_i` MSB first. For each bit, SCL goes low, SDA changes one tick later, then SCL goes high for two ticks. SDA never changes while SCL is high. The command lasts 37 ticks.
- R4: During the ninth write clock, SDA is released. The engine samples the line two ticks after SCL rises and shows the level on `ack_o`: 0 means acknowledged, 1 means not acknowledged.
- R5: Read (code 4) keeps SDA released for 8 clocks. It samples SDA one tick after each SCL rise and shifts the bits in MSB first. The byte is on `rdata_o` at `done_o`. The command lasts 29 ticks.
- R6: After a read byte, the engine drives the `ack_i` level captured at command accept during a ninth clock. 0 pulls SDA low; 1 leaves it released. SCL is high for two ticks in this clock.
- R7: Recovery (code 5) gives 9 SCL pulses with SDA released, each low and high phase lasting two ticks. It then runs a STOP and ends with both lines released, 40 ticks in total.
- R8: One tick equals `TICK_DIV` clock cycles, counted from command accept. `done_o` is a single-cycle pulse that rises `ticks*TICK_DIV` cycles after the accepting edge.
- R9: A command presented while `busy_o` is high is ignored. Codes 0, 6 and 7 are ignored at all times. An ignored command starts no bus activity and sets neither `busy_o` nor `done_o`.
- R10: Reset (`rst_ni` low) immediately returns the engine to idle with both lines released and `busy_o` and `done_o` low. This holds even in the middle of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken when idle |
| cmd_i | input | 3 | Command code (1 START, 2 STOP, 3 write, 4 read, 5 recovery) |
| wdata_i | input | 8 | Byte to send for a write |
| ack_i | input | 1 | Acknowledge level to send after a read byte |
| sda_i | input | 1 | Data line level |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte received by the last read |
| ack_o | output | 1 | Acknowledge level sampled by the last write |
| scl_oe_o | output | 1 | Pull clock line low when 1 |
| sda_oe_o | output | 1 | Pull data line low when 1 |

## Verification
A small slave model on the open-drain bus answers each command, and the bench tries the engine with several byte patterns:
- **Write bytes:** alternating bits, a run of zeros, and a single set MSB. Reading each bit back at SCL rise catches a bit-order or shift-timing error, and acknowledge and non-acknowledge answers must separate on `ack_o`.
- **Read bytes:** asymmetric patterns such as a single LSB and mixed nibbles. These show whether sampling falls in the right clock and in MSB-first order, and reads with both acknowledge choices show that the engine drives, or leaves released, the ninth bit.
- **Recovery:** runs from an idle bus, and the bench measures the pulse count, the SCL high time and the closing STOP.
- **Ignored commands:** these come during a command and with unused codes.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int BYTE_W     = 8;
  localparam int RCV_PULSES = 9;
  localparam int BIT_CNT_W  = 4;
  localparam int STEP_W     = 3;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_START   = 3'd1,
    CMD_STOP    = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_READ    = 3'd4,
    CMD_RECOVER = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_STOP, S_WBIT, S_WACK, S_RBIT, S_RACK, S_RCV
  } state_e;

  function automatic logic cmd_legal(logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd5);
  endfunction
endpackage

// File: rtl/i2c_tick_gen.sv
module i2c_tick_gen #(
  parameter int TICK_DIV = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LOAD = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && !restart_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= LOAD;
    else if (restart_i || tick_o)  cnt_q <= LOAD;
    else if (run_i)                cnt_q <= cnt_q - 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD); // R8

  if (TICK_DIV > 1) begin : g_gap
    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o); // R8
  end
endmodule

// File: rtl/i2c_eng_seq.sv
module i2c_eng_seq
  import i2c_eng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              sda_i,
  input  logic              tick_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              scl_o,
  output logic              sda_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              ack_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT   = BIT_CNT_W'(BYTE_W - 1);
  localparam logic [BIT_CNT_W-1:0] LAST_PULSE = BIT_CNT_W'(RCV_PULSES - 1);

  state_e                state_q;
  logic [STEP_W-1:0]     step_q;
  logic [BIT_CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0]     sh_q;
  logic                  scl_q, sda_q, ack_lvl_q, ack_q, done_q;

  assign accept_o = (state_q == S_IDLE) && cmd_valid_i && cmd_legal(cmd_i);
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign scl_o    = scl_q;
  assign sda_o    = sda_q;
  assign rdata_o  = sh_q;
  assign ack_o    = ack_q;

  // each tick ends the current step and applies the action of the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      step_q    <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      ack_lvl_q <= 1'b1;
      ack_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        step_q <= '0;
        bit_q  <= '0;
        case (cmd_i)
          CMD_START:   state_q <= S_START;
          CMD_STOP:    begin state_q <= S_STOP; scl_q <= 1'b0; end
          CMD_WRITE:   begin state_q <= S_WBIT; sh_q <= wdata_i; scl_q <= 1'b0; end
          CMD_READ:    begin state_q <= S_RBIT; scl_q <= 1'b0; sda_q <= 1'b1; ack_lvl_q <= ack_i; end
          CMD_RECOVER: begin state_q <= S_RCV;  scl_q <= 1'b0; sda_q <= 1'b1; end
          default: ;
        endcase
      end else if (tick_i) begin
        step_q <= step_q + 1'b1;
        case (state_q)
          S_START: case (step_q)
            3'd0:    sda_q <= 1'b1;
            3'd1:    scl_q <= 1'b1;
            3'd2:    sda_q <= 1'b0;
            default: begin state_q <= S_IDLE; done_q <= 1'b1; end
          endcase
          S_STOP: case (step_q)
            3'd0:    sda_q <= 1'b0;
            3'd1:    scl_q <= 1'b1;
            3'd2:    sda_q <= 1'b1;
            default: begin state_q <= S_IDLE; done_q <= 1'b1; end
          endcase
          S_WBIT: case (step_q)
            3'd0:    sda_q <= sh_q[BYTE_W-1];
            3'd1:    scl_q <= 1'b1;
            3'd2:    ;
            default: begin
              step_q <= '0;
              scl_q  <= 1'b0;
              sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
              if (bit_q == LAST_BIT) state_q <= S_WACK;
              else                   bit_q   <= bit_q + 1'b1;
            end
          endcase
          S_WACK: case (step_q)
            3'd0:    sda_q <= 1'b1;
            3'd1:    scl_q <= 1'b1;
            3'd2:    ;
            3'd3:    begin ack_q <= sda_i; scl_q <= 1'b0; end
            default: begin state_q <= S_IDLE; done_q <= 1'b1; end
          endcase
          S_RBIT: case (step_q)
            3'd0:    scl_q <= 1'b1;
            3'd1:    sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            default: begin
              step_q <= '0;
              scl_q  <= 1'b0;
              if (bit_q == LAST_BIT) state_q <= S_RACK;
              else                   bit_q   <= bit_q + 1'b1;
            end
          endcase
          S_RACK: case (step_q)
            3'd0:    sda_q <= ack_lvl_q;
            3'd1:    scl_q <= 1'b1;
            3'd2:    ;
            3'd3:    scl_q <= 1'b0;
            default: begin state_q <= S_IDLE; done_q <= 1'b1; end
          endcase
          S_RCV: case (step_q)
            3'd0:    ;
            3'd1:    scl_q <= 1'b1;
            3'd2:    ;
            default: begin
              step_q <= '0;
              scl_q  <= 1'b0;
              if (bit_q == LAST_PULSE) state_q <= S_STOP;
              else                     bit_q   <= bit_q + 1'b1;
            end
          endcase
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q inside {S_WBIT, S_WACK, S_RBIT, S_RACK}) && $past(scl_q) && scl_q)
      |-> $stable(sda_q)); // R3
  AST_WACK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WACK && step_q != '0) |-> sda_q); // R4
  AST_READ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RBIT) |-> sda_q); // R5
  AST_RCV_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RCV) |-> sda_q); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(state_q) && $stable(scl_q) && $stable(sda_q))); // R9
  AST_STOP_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && $past(state_q) == S_STOP) |-> (scl_q && sda_q)); // R2
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_eng_pkg::*;
#(
  parameter int TICK_DIV = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              sda_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  logic tick, accept, scl_lvl, sda_lvl;

  i2c_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_o),
    .restart_i (accept),
    .tick_o    (tick)
  );

  i2c_eng_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .wdata_i     (wdata_i),
    .ack_i       (ack_i),
    .sda_i       (sda_i),
    .tick_i      (tick),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .scl_o       (scl_lvl),
    .sda_o       (sda_lvl),
    .rdata_o     (rdata_o),
    .ack_o       (ack_o)
  );

  // open drain: enable only pulls low
  assign scl_oe_o = !scl_lvl;
  assign sda_oe_o = !sda_lvl;

  AST_IDLE_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !done_o); // R9
endmodule

// File: tb/sim_i2c_bit_engine.sv
module sim_i2c_bit_engine;
  localparam int D = 4;
  localparam logic [2:0] C_START = 3'd1, C_STOP = 3'd2, C_WR = 3'd3, C_RD = 3'd4, C_RCV = 3'd5;

  typedef struct packed {
    logic [2:0] cmd;
    logic [7:0] data;
    logic       sack;
    logic       ack_in;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{C_WR, 8'hA5, 1'b1, 1'b0},
    '{C_WR, 8'h00, 1'b0, 1'b0},
    '{C_RD, 8'h96, 1'b0, 1'b0},
    '{C_RD, 8'h01, 1'b0, 1'b1},
    '{C_WR, 8'h80, 1'b1, 1'b0},
    '{C_RD, 8'h5B, 1'b0, 1'b1}
  };

  logic clk_i = 1'b0;
  always #4 clk_i = ~clk_i;

  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [7:0] wdata_i = 8'h00;
  logic       ack_i = 1'b1;
  logic       sda_i;
  logic       busy_o, done_o, ack_o, scl_oe_o, sda_oe_o;
  logic [7:0] rdata_o;

  i2c_bit_engine #(.TICK_DIV(D)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .wdata_i(wdata_i), .ack_i(ack_i), .sda_i(sda_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .ack_o(ack_o),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  // bus monitor and slave model
  int         checks = 0, fails = 0, cyc = 0;
  int         rise_cnt = 0, base_rise = 0, hi_fall = 0, hi_rise = 0, low_rises = 0;
  int         rise_t = 0, last_hi = 0;
  logic       scl_seen = 1'b1, sda_seen = 1'b1;
  logic [8:0] cap = '0;
  int         slv_mode = 0;  // 0 quiet, 1 acks a write, 2 sends a byte
  logic [7:0] slv_byte = '0;
  logic       slv_ack = 1'b0;
  logic       slv_pull;
  int         k_idx;

  always_comb begin
    k_idx    = (rise_cnt - base_rise) - (scl_seen ? 1 : 0);
    slv_pull = 1'b0;
    if (slv_mode == 1 && k_idx == 8) slv_pull = slv_ack;
    if (slv_mode == 2 && k_idx >= 0 && k_idx < 8) slv_pull = !slv_byte[7 - k_idx];
  end
  assign sda_i = !(sda_oe_o || slv_pull);

  always @(negedge clk_i) begin
    logic scl_l, sda_l;
    cyc++;
    scl_l = !scl_oe_o;
    sda_l = sda_i;
    if (scl_seen && scl_l && sda_seen && !sda_l) hi_fall++;
    if (scl_seen && scl_l && !sda_seen && sda_l) hi_rise++;
    if (!scl_seen && scl_l) begin
      rise_cnt++;
      cap = {cap[7:0], sda_l};
      rise_t = cyc;
      if (!sda_l) low_rises++;
    end
    if (scl_seen && !scl_l) last_hi = cyc - rise_t;
    scl_seen = scl_l;
    sda_seen = sda_l;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int b_fall, b_rise, b_low;

  task automatic run(input logic [2:0] c, input logic [7:0] d, input logic a,
                     input int mode, input logic sack, output int lat);
    @(negedge clk_i);
    slv_mode = mode; slv_byte = d; slv_ack = sack; base_rise = rise_cnt;
    b_fall = hi_fall; b_rise = hi_rise; b_low = low_rises;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = c; wdata_i = d; ack_i = a;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 5000) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  initial begin
    int lat, busy_cnt, r0;
    repeat (3) @(negedge clk_i);
    chk(!scl_oe_o && !sda_oe_o, "R10 lines released in reset", {scl_oe_o, sda_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R10 idle after reset", {busy_o, done_o}, 0);
    chk(!scl_oe_o && !sda_oe_o, "R10 lines released after reset", {scl_oe_o, sda_oe_o}, 0);

    // R1
    run(C_START, 8'h00, 1'b1, 0, 1'b0, lat);
    chk(lat == 4*D + 1, "R1 R8 START latency", lat, 4*D + 1);
    chk(hi_fall - b_fall == 1 && hi_rise == b_rise, "R1 SDA falls with SCL high", hi_fall - b_fall, 1);
    chk(!scl_oe_o && sda_oe_o, "R1 START end state", {scl_oe_o, sda_oe_o}, 1);
    @(negedge clk_i);
    chk(!done_o, "R8 done single cycle", done_o, 0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      v = VECS[i];
      if (v.cmd == C_WR) begin
        run(C_WR, v.data, 1'b1, 1, v.sack, lat);
        chk(lat == 37*D + 1, "R3 R8 write latency", lat, 37*D + 1);
        chk(cap[8:1] == v.data, "R3 write bits MSB first", cap[8:1], v.data);
        chk(hi_fall == b_fall && hi_rise == b_rise, "R3 SDA steady while SCL high",
            hi_fall + hi_rise - b_fall - b_rise, 0);
        chk(ack_o == !v.sack, "R4 sampled acknowledge", ack_o, !v.sack);
        chk(cap[0] == !v.sack, "R4 SDA released in ninth clock", cap[0], !v.sack);
      end else begin
        run(C_RD, v.data, v.ack_in, 2, 1'b0, lat);
        chk(lat == 29*D + 1, "R5 R8 read latency", lat, 29*D + 1);
        chk(rdata_o == v.data, "R5 read byte", rdata_o, v.data);
        chk(hi_fall == b_fall && hi_rise == b_rise, "R5 SDA steady while SCL high",
            hi_fall + hi_rise - b_fall - b_rise, 0);
        chk(cap[0] == v.ack_in, "R6 acknowledge driven after read", cap[0], v.ack_in);
      end
    end

    // R2
    run(C_STOP, 8'h00, 1'b1, 0, 1'b0, lat);
    chk(lat == 4*D + 1, "R2 R8 STOP latency", lat, 4*D + 1);
    chk(hi_rise - b_rise == 1 && hi_fall == b_fall, "R2 SDA rises with SCL high", hi_rise - b_rise, 1);
    chk(!scl_oe_o && !sda_oe_o, "R2 lines released", {scl_oe_o, sda_oe_o}, 0);

    // R7
    run(C_RCV, 8'h00, 1'b1, 0, 1'b0, lat);
    chk(lat == 40*D + 1, "R7 R8 recovery latency", lat, 40*D + 1);
    chk(rise_cnt - base_rise == 10, "R7 nine pulses plus STOP", rise_cnt - base_rise, 10);
    chk(low_rises - b_low == 1, "R7 SDA released during pulses", low_rises - b_low, 1);
    chk(last_hi == 2*D, "R7 SCL high two ticks", last_hi, 2*D);
    chk(hi_rise - b_rise == 1 && hi_fall == b_fall, "R7 closing STOP", hi_rise - b_rise, 1);
    chk(!scl_oe_o && !sda_oe_o, "R7 lines released", {scl_oe_o, sda_oe_o}, 0);

    // R9 unused code while idle
    r0 = rise_cnt;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = 3'd7;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    busy_cnt = 0;
    for (int j = 0; j < 10*D; j++) begin
      @(negedge clk_i);
      if (busy_o || done_o || scl_oe_o || sda_oe_o) busy_cnt++;
    end
    chk(busy_cnt == 0 && rise_cnt == r0, "R9 unused code ignored", busy_cnt, 0);

    // R9 command while busy
    run(C_START, 8'h00, 1'b1, 0, 1'b0, lat);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = C_START;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    lat = 0;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_i = C_STOP;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy during START", busy_o, 1);
    r0 = rise_cnt;
    busy_cnt = 0;
    for (int j = 0; j < 40*D; j++) begin
      @(negedge clk_i);
      if (done_o) lat++;
    end
    chk(lat == 1, "R9 one done for one accepted command", lat, 1);
    chk(!busy_o && rise_cnt == r0, "R9 STOP during busy ignored", rise_cnt - r0, 0);
    chk(!scl_oe_o && sda_oe_o, "R9 START state kept", {scl_oe_o, sda_oe_o}, 1);

    // R10 reset mid-command
    @(negedge clk_i);
    slv_mode = 0;
    cmd_valid_i = 1'b1; cmd_i = C_WR; wdata_i = 8'h00;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    repeat (6*D) @(negedge clk_i);
    chk(busy_o && sda_oe_o, "R10 write in progress", {busy_o, sda_oe_o}, 3);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !done_o && !scl_oe_o && !sda_oe_o, "R10 reset aborts command",
        {busy_o, done_o, scl_oe_o, sda_oe_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !scl_oe_o && !sda_oe_o, "R10 idle after abort", {busy_o, scl_oe_o, sda_oe_o}, 0);

    summary();
    $finish;
  end
endmodule